// File: doc/BRIEF.md
# Compare and Record Field Generator

This unit produces one four-bit condition field per accepted operation and names which of a small set of condition fields should receive it. An explicit compare takes operand A and compares it with either operand B or a 16-bit immediate, as signed or unsigned values. When the operation is unsigned the immediate is zero-extended, and when it is signed the immediate is sign-extended. A record-mode operation instead takes operand A as the result of an arithmetic operation and compares it with zero. That comparison is always signed.

The fourth bit of the field carries the summary overflow flag. For explicit compares it is the flag exactly as presented. For record mode the unit ORs in the overflow that the same operation raises, so the bit already includes that operation's own overflow. The arithmetic unit and the condition register file sit outside this block. The result appears on registered outputs one clock after the input is accepted, together with a write enable and a field index.

Top module: `cmp_field_unit`

## Requirements
- R1: While reset is high and after it falls (before any valid input), fld_we, fld_idx and fld_val are all zero.
- R2: fld_we is high in exactly the cycle after a cycle with in_valid high, and low otherwise. fld_val and fld_idx hold their last value while fld_we is low.
- R3: The field layout is fld_val[3]=less, fld_val[2]=greater, fld_val[1]=equal, fld_val[0]=summary overflow. Whenever fld_we is high, exactly one of bits 3..1 is set.
- R4: With rec_mode=0, use_imm=0 and is_signed=1, opa and opb are compared as two's-complement values.
- R5: With rec_mode=0, use_imm=0 and is_signed=0, opa and opb are compared as unsigned values.
- R6: With rec_mode=0, use_imm=1 and is_signed=1, the immediate is sign-extended from bit 15 before a signed compare.
- R7: With rec_mode=0, use_imm=1 and is_signed=0, the immediate is zero-extended before an unsigned compare.
- R8: With rec_mode=0, fld_val[0] equals the sum_ovf_in value that was sampled with the operation.
- R9: With rec_mode=0, fld_idx is dst_idx when dst_given=1, and field 0 when dst_given=0.
- R10: With rec_mode=1, opa is compared with zero as a signed value whatever is_signed says, and opb, imm and use_imm have no effect.
- R11: With rec_mode=1, fld_val[0] is sum_ovf_in OR ovf_now, and fld_idx is 0 whatever dst_given and dst_idx say.
- R12: With rec_mode=0, ovf_now has no effect on fld_val[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| opa | input | 32 | Left operand, or arithmetic result in record mode |
| opb | input | 32 | Right register operand |
| imm | input | 16 | Immediate right operand |
| use_imm | input | 1 | Select the immediate instead of opb |
| is_signed | input | 1 | Signed compare (explicit mode only) |
| dst_given | input | 1 | dst_idx is valid |
| dst_idx | input | 3 | Requested destination field |
| rec_mode | input | 1 | Compare opa with zero (record form) |
| sum_ovf_in | input | 1 | Current summary overflow flag |
| ovf_now | input | 1 | Overflow raised by this same operation |
| fld_we | output | 1 | Field write enable |
| fld_idx | output | 3 | Destination field index |
| fld_val | output | 4 | Condition field: less, greater, equal, overflow |

## Verification
Every internal path ends one register away from the ports, so a fault shows up on the first write that uses it. A wrong extension or signedness choice gives the wrong one of less or greater on the next fld_we. This is visible only for operands near the sign boundary or immediates with bit 15 set, and the bench aims at those values. A wrong overflow merge or a wrong destination rule shows up as a bad bit 0 or a bad index on that same write. A fault in the enable register appears as a write in an idle cycle, or as a missing write.

// File: rtl/cmp_field_pkg.sv
package cmp_field_pkg;
  // Condition field, most significant bit first: less, greater, equal, overflow.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } rel_t;
endpackage

// File: rtl/cmp_operand_sel.sv
module cmp_operand_sel #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             is_signed,
  input  logic             rec_mode,
  output logic [W-1:0]     b_eff,
  output logic             sgn_eff
);
  localparam int PAD_W = (W > IMM_W) ? (W - IMM_W) : 1;

  logic [W-1:0] imm_ext;

  generate
    if (W > IMM_W) begin : g_pad
      logic [PAD_W-1:0] pad;
      assign pad     = {PAD_W{is_signed & imm[IMM_W-1]}};
      assign imm_ext = {pad, imm};
    end else begin : g_trunc
      assign imm_ext = imm[W-1:0];
    end
  endgenerate

  // Record form: signed compare against zero.
  always_comb begin
    sgn_eff = rec_mode | is_signed;
    if (rec_mode)     b_eff = '0;
    else if (use_imm) b_eff = imm_ext;
    else              b_eff = opb;
  end
endmodule

// File: rtl/cmp_magnitude.sv
module cmp_magnitude
  import cmp_field_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output rel_t         rel
);
  logic signed [W:0] a_x;
  logic signed [W:0] b_x;

  // One guard bit turns signed and unsigned into one signed compare.
  always_comb begin
    a_x    = {sgn & a[W-1], a};
    b_x    = {sgn & b[W-1], b};
    rel.eq = (a == b);
    rel.lt = (a_x < b_x);
    rel.gt = ~rel.eq & ~rel.lt;
  end
endmodule

// File: rtl/cmp_field_stage.sv
module cmp_field_stage
  import cmp_field_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int DEF_FIELD = 0,
  parameter int REC_FIELD = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  rel_t             rel,
  input  logic             rec_mode,
  input  logic             sum_ovf_in,
  input  logic             ovf_now,
  input  logic             dst_given,
  input  logic [IDX_W-1:0] dst_idx,
  output logic             fld_we,
  output logic [IDX_W-1:0] fld_idx,
  output cond_t            fld_val
);
  logic             so_nxt;
  logic [IDX_W-1:0] idx_nxt;
  cond_t            val_nxt;

  always_comb begin
    // Record form sees the flag after its own overflow update.
    so_nxt = rec_mode ? (sum_ovf_in | ovf_now) : sum_ovf_in;
    if (rec_mode)       idx_nxt = IDX_W'(REC_FIELD);
    else if (dst_given) idx_nxt = dst_idx;
    else                idx_nxt = IDX_W'(DEF_FIELD);
    val_nxt = '{lt: rel.lt, gt: rel.gt, eq: rel.eq, so: so_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_we  <= 1'b0;
      fld_idx <= '0;
      fld_val <= '0;
    end else begin
      fld_we <= in_valid;
      if (in_valid) begin
        fld_idx <= idx_nxt;
        fld_val <= val_nxt;
      end
    end
  end
endmodule

// File: rtl/cmp_field_unit.sv
module cmp_field_unit
  import cmp_field_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int FIELDS = 8,
  localparam int IDX_W = (FIELDS > 1) ? $clog2(FIELDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             is_signed,
  input  logic             dst_given,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             rec_mode,
  input  logic             sum_ovf_in,
  input  logic             ovf_now,
  output logic             fld_we,
  output logic [IDX_W-1:0] fld_idx,
  output logic [3:0]       fld_val
);
  logic [W-1:0] b_eff;
  logic         sgn_eff;
  rel_t         rel;
  cond_t        val_q;

  cmp_operand_sel #(.W(W), .IMM_W(IMM_W)) u_sel (
    .opb(opb), .imm(imm), .use_imm(use_imm), .is_signed(is_signed),
    .rec_mode(rec_mode), .b_eff(b_eff), .sgn_eff(sgn_eff)
  );

  cmp_magnitude #(.W(W)) u_cmp (
    .a(opa), .b(b_eff), .sgn(sgn_eff), .rel(rel)
  );

  cmp_field_stage #(.IDX_W(IDX_W), .DEF_FIELD(0), .REC_FIELD(0)) u_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rel(rel),
    .rec_mode(rec_mode), .sum_ovf_in(sum_ovf_in), .ovf_now(ovf_now),
    .dst_given(dst_given), .dst_idx(dst_idx),
    .fld_we(fld_we), .fld_idx(fld_idx), .fld_val(val_q)
  );

  assign fld_val = val_q;
endmodule

// File: rtl/cmp_field_chk.sv
module cmp_field_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             dst_given,
  input logic             rec_mode,
  input logic             sum_ovf_in,
  input logic             ovf_now,
  input logic             fld_we,
  input logic [IDX_W-1:0] fld_idx,
  input logic [3:0]       fld_val
);
  p_we_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> fld_we);
  p_we_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !fld_we);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(fld_val) && $stable(fld_idx)));
  p_one_rel_r3: assert property (@(posedge clk) disable iff (rst)
    fld_we |-> ($countones(fld_val[3:1]) == 1));
  p_so_copy_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec_mode) |=> (fld_val[0] == $past(sum_ovf_in)));
  p_default_idx_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec_mode && !dst_given) |=> (fld_idx == '0));
  p_rec_so_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rec_mode) |=> (fld_val[0] == ($past(sum_ovf_in) | $past(ovf_now))));
  p_rec_idx_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rec_mode) |=> (fld_idx == '0));
endmodule

bind cmp_field_unit cmp_field_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dst_given(dst_given),
  .rec_mode(rec_mode), .sum_ovf_in(sum_ovf_in), .ovf_now(ovf_now),
  .fld_we(fld_we), .fld_idx(fld_idx), .fld_val(fld_val)
);

// File: tb/tb_cmp_field_unit.sv
`timescale 1ns/1ps
module tb_cmp_field_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0, is_signed = 1'b0, dst_given = 1'b0;
  logic [2:0]  dst_idx = '0;
  logic        rec_mode = 1'b0, sum_ovf_in = 1'b0, ovf_now = 1'b0;
  logic        fld_we;
  logic [2:0]  fld_idx;
  logic [3:0]  fld_val;

  always #2.5 clk = ~clk;

  cmp_field_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb), .imm(imm),
    .use_imm(use_imm), .is_signed(is_signed), .dst_given(dst_given),
    .dst_idx(dst_idx), .rec_mode(rec_mode), .sum_ovf_in(sum_ovf_in),
    .ovf_now(ovf_now), .fld_we(fld_we), .fld_idx(fld_idx), .fld_val(fld_val)
  );

  typedef struct {
    logic [3:0] val;
    logic [2:0] idx;
    int         due;
    string      req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit armed = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected field from the requirements, using 64-bit arithmetic.
  function automatic logic [3:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] im, input logic ui, input logic sg, input logic rm,
      input logic so_in, input logic ov);
    longint la, lb;
    logic [31:0] rb;
    logic s, so;
    s  = rm ? 1'b1 : sg;
    rb = rm ? 32'd0 : (ui ? (sg ? {{16{im[15]}}, im} : {16'd0, im}) : b);
    la = s ? longint'($signed(a))  : longint'({32'd0, a});
    lb = s ? longint'($signed(rb)) : longint'({32'd0, rb});
    so = rm ? (so_in | ov) : so_in;
    return {la < lb, la > lb, la == lb, so};
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
      input logic ui, input logic sg, input logic dg, input logic [2:0] di,
      input logic rm, input logic so_in, input logic ov, input string req);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; opa = a; opb = b; imm = im; use_imm = ui; is_signed = sg;
    dst_given = dg; dst_idx = di; rec_mode = rm; sum_ovf_in = so_in; ovf_now = ov;
    e.val = model(a, b, im, ui, sg, rm, so_in, ov);
    e.idx = rm ? 3'd0 : (dg ? di : 3'd0);
    e.due = cyc + 1;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      opa = 32'hDEAD_BEEF; ovf_now = 1'b1;
    end
  endtask

  // Monitor: compares outputs with the scoreboard between clock edges.
  always @(negedge clk) begin
    if (armed && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        checks++;
        if (!fld_we || fld_val !== q[0].val || fld_idx !== q[0].idx) begin
          errors++;
          $display("FAIL %s: we=%b val=%b idx=%0d expected we=1 val=%b idx=%0d",
                   q[0].req, fld_we, fld_val, fld_idx, q[0].val, q[0].idx);
        end
        void'(q.pop_front());
      end else begin
        checks++;
        if (fld_we !== 1'b0) begin
          errors++;
          $display("FAIL R2: idle cycle we=%b expected 0", fld_we);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (fld_we !== 0 || fld_idx !== 0 || fld_val !== 0) begin
      errors++;
      $display("FAIL R1: in reset we=%b idx=%0d val=%b expected 0 0 0000", fld_we, fld_idx, fld_val);
    end
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    checks++;
    if (fld_we !== 0 || fld_idx !== 0 || fld_val !== 0) begin
      errors++;
      $display("FAIL R1: after reset we=%b idx=%0d val=%b expected 0 0 0000", fld_we, fld_idx, fld_val);
    end
    armed = 1;

    send(32'hFFFF_FFFB, 32'd3, 16'h0, 0, 1, 0, 0, 0, 0, 0, "R4");
    send(32'd7, 32'd7, 16'h0, 0, 1, 0, 0, 0, 0, 0, "R4");
    send(32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 0, 1, 0, 0, 0, 0, 0, "R4");
    idle(2);
    send(32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 0, 0, 0, 0, 0, 0, 0, "R5");
    send(32'hFFFF_FFFF, 32'd1, 16'h0, 0, 0, 0, 0, 0, 0, 0, "R5");
    send(32'hFFFF_FFFF, 32'd5, 16'hFFFF, 1, 1, 0, 0, 0, 0, 0, "R6");
    send(32'd5, 32'd0, 16'h8000, 1, 1, 0, 0, 0, 0, 0, "R6");
    send(32'hFFFF_8000, 32'd0, 16'h8000, 1, 1, 0, 0, 0, 0, 0, "R6");
    send(32'hFFFF_FFFF, 32'd0, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0, "R7");
    send(32'h0000_FFFF, 32'd9, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0, "R7");
    idle(1);
    send(32'd1, 32'd2, 16'h0, 0, 1, 0, 0, 0, 1, 0, "R8");
    send(32'd1, 32'd2, 16'h0, 0, 1, 0, 0, 0, 0, 1, "R12");
    send(32'd1, 32'd2, 16'h0, 0, 1, 1, 3'd5, 0, 0, 0, "R9");
    send(32'd1, 32'd2, 16'h0, 0, 1, 0, 3'd6, 0, 0, 0, "R9");
    send(32'h8000_0000, 32'hFFFF_FFFF, 16'h1234, 1, 0, 0, 0, 1, 0, 0, "R10");
    send(32'd0, 32'd77, 16'hFFFF, 0, 0, 0, 0, 1, 0, 0, "R10");
    send(32'd1, 32'h8000_0000, 16'h0, 0, 0, 0, 0, 1, 0, 0, "R10");
    send(32'd4, 32'd1, 16'h0, 0, 1, 1, 3'd3, 1, 0, 0, "R11");
    send(32'd4, 32'd1, 16'h0, 0, 1, 0, 0, 1, 0, 1, "R11");
    send(32'd4, 32'd1, 16'h0, 0, 1, 0, 0, 1, 1, 0, "R11");
    idle(3);
    x = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      send(x, {x[15:0], x[31:16]}, x[23:8], x[0], x[1], x[2], x[5:3], x[6] & x[7],
           x[8], x[9], "R3");
      if (x[10] && x[11]) idle(1);
    end
    idle(4);
    done = 1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d writes missing, expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule